// File: doc/BRIEF.md
# Frame Size Statistics Counters

This block holds two banks of 32-bit event counters, one fed by the transmit path and one by the receive path. Each side reports a finished frame with a one-cycle strobe and the frame's byte length. On that strobe the side's bank updates several counters in the same clock. The frame count and the good-frame count each step by one. The octet total and the good-octet total each grow by the length. The one size-class counter that matches the length also steps by one.

Software reaches every counter through a word-addressed window in a 10-bit byte address space. A read returns the counter value in the same cycle. A write replaces the counter value. Both directions can report frames in the same cycle, and neither update is lost. Window slots with no counter behind them read as zero.

Top module: `fstat_top`

## Requirements
- R1: A transmit strobe (`tx_done`=1) adds one to the transmit frame counter (index 1) and to the transmit good-frame counter (index 19). The new values are visible from the cycle after the strobe's clock edge. With no strobe and no write, the counters hold their value.
- R2: A transmit strobe adds `tx_len` to the transmit octet counter (index 17) and to the transmit good-octet counter (index 29).
- R3: A transmit strobe adds one to exactly one size-class counter, chosen by length. Below 64 goes to index 7. Exactly 64 goes to index 10. 65–127 goes to index 11, 128–255 to 12, 256–511 to 13, 512–1023 to 14 and 1024–2047 to 15. 2048 and above goes to index 16.
- R4: A receive strobe (`rx_done`=1, length `rx_len`) updates the receive bank in the same way. The frame counter is index 33, the good-frame counter 51, the octet counter 49 and the good-octet counter 56. The size classes, in the order of R3, are indices 39, 42, 43, 44, 45, 46, 47 and 48.
- R5: Transmit and receive strobes in the same cycle both take full effect.
- R6: Counter n sits at byte address 0x200 + 4·n, for n from 0 to 63. Address bits [1:0] are ignored. `csr_rdata` shows the addressed counter combinationally.
- R7: A write (`csr_wr`=1) replaces the addressed counter with `csr_wdata` at the next clock edge. If a strobe hits the same counter in that cycle, the written value is kept.
- R8: Every counter wraps modulo 2^32.
- R9: Window indices with no counter, and any address outside 0x200–0x2FF, read as zero. Writes to them change nothing.
- R10: A synchronous active-high `rst` clears every counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | Transmit frame finished strobe |
| tx_len | input | 16 | Transmit frame length in bytes |
| rx_done | input | 1 | Receive frame finished strobe |
| rx_len | input | 16 | Receive frame length in bytes |
| csr_wr | input | 1 | Register write enable |
| csr_addr | input | 10 | Register byte address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |

## Verification
Every counter result from a strobe or a write is due one clock edge after the cycle in which the inputs were applied. Read data follows the address with no clock in between. The bench drives inputs on the falling edge and samples `csr_rdata` 1 ns later, comparing it against the model state from before the next rising edge. Only after that edge does it fold the cycle's strobes and write into the model, with the write applied last. This way every comparison sees exactly the updates that are due.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
    localparam int CNT_W    = 32;
    localparam int LEN_W    = 16;
    localparam int ADDR_W   = 10;
    localparam int IDX_W    = 6;
    localparam int WIN_PAGE = 2;      // address bits [9:8] select the window
    localparam int NBKT     = 8;      // fragment class plus seven size classes
    localparam int NSLOT    = 4 + NBKT;
    localparam int TX_BASE  = 0;
    localparam int RX_BASE  = 32;
    localparam int TX_GOCT  = 29;
    localparam int RX_GOCT  = 24;

    typedef enum int {
        SL_PKT  = 0,
        SL_OCT  = 1,
        SL_GOOD = 2,
        SL_GOCT = 3,
        SL_BKT  = 4
    } slot_e;

    // Position of a slot relative to its bank base.
    function automatic int slot_rel(input int k, input int goct);
        case (k)
            SL_PKT:  return 1;
            SL_OCT:  return 17;
            SL_GOOD: return 19;
            SL_GOCT: return goct;
            SL_BKT:  return 7;
            default: return k + 5;
        endcase
    endfunction

    // Inclusive lower bound of size class b (b >= 1).
    function automatic int bkt_lo(input int b);
        if (b == 1) return 64;
        if (b == 2) return 65;
        return 1 << (b + 4);
    endfunction

    // Exclusive upper bound of size class b (b <= NBKT-2).
    function automatic int bkt_hi(input int b);
        if (b == 0) return 64;
        if (b == 1) return 65;
        return 1 << (b + 5);
    endfunction
endpackage

// File: rtl/fstat_sort.sv
module fstat_sort
    import fstat_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic [LW-1:0]   len,
    output logic [NBKT-1:0] bkt
);
    localparam logic [31:0] LEN_PAD = 32'(0);
    logic [31:0] len32;
    assign len32 = LEN_PAD | 32'(len);

    for (genvar b = 0; b < NBKT; b++) begin : g_bkt
        if (b == 0) begin : g_frag
            assign bkt[b] = len32 < 32'(bkt_hi(b));
        end else if (b == NBKT - 1) begin : g_top
            assign bkt[b] = len32 >= 32'(bkt_lo(b));
        end else begin : g_mid
            assign bkt[b] = (len32 >= 32'(bkt_lo(b))) && (len32 < 32'(bkt_hi(b)));
        end
    end
endmodule

// File: rtl/fstat_bank.sv
module fstat_bank
    import fstat_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int LW    = LEN_W,
    parameter int IW    = IDX_W,
    parameter int BASE  = 0,
    parameter int GOCT  = 29
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic [LW-1:0] len,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] wdata,
    output logic          rd_hit,
    output logic [CW-1:0] rd_val
);
    logic [NBKT-1:0] bkt;
    logic [CW-1:0]   cnt_q  [NSLOT];
    logic [CW-1:0]   inc_w  [NSLOT];
    logic            hit_w  [NSLOT];

    fstat_sort #(.LW(LW)) u_sort (
        .len (len),
        .bkt (bkt)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        localparam logic [IW-1:0] ABS = IW'(BASE + slot_rel(k, GOCT));

        assign hit_w[k] = wr_en && (idx == ABS);

        if (k == SL_OCT || k == SL_GOCT) begin : g_sum
            assign inc_w[k] = evt ? CW'(len) : '0;
        end else if (k == SL_PKT || k == SL_GOOD) begin : g_cnt
            assign inc_w[k] = CW'(evt);
        end else begin : g_cls
            assign inc_w[k] = CW'(evt && bkt[k - SL_BKT]);
        end

        always_ff @(posedge clk) begin
            if (rst)           cnt_q[k] <= '0;
            else if (hit_w[k]) cnt_q[k] <= wdata;
            else               cnt_q[k] <= cnt_q[k] + inc_w[k];
        end
    end

    always_comb begin
        rd_hit = 1'b0;
        rd_val = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (idx == IW'(BASE + slot_rel(k, GOCT))) begin
                rd_hit = 1'b1;
                rd_val = cnt_q[k];
            end
        end
    end

    // R1: frame counter steps by one on a strobe
    p_pkt_step_r1: assert property (@(posedge clk) disable iff (rst)
        (evt && !hit_w[SL_PKT]) |=> cnt_q[SL_PKT] == $past(cnt_q[SL_PKT]) + CW'(1));

    // R1: frame counter holds when idle
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!evt && !wr_en) |=> $stable(cnt_q[SL_PKT]));

    // R2: octet counter grows by the length
    p_oct_add_r2: assert property (@(posedge clk) disable iff (rst)
        (evt && !hit_w[SL_OCT]) |=> cnt_q[SL_OCT] == $past(cnt_q[SL_OCT]) + CW'($past(len)));

    // R3: exactly one size class per frame
    p_one_class_r3: assert property (@(posedge clk) disable iff (rst)
        evt |-> $onehot(bkt));

    // R7: a write wins over a same-cycle increment
    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        hit_w[SL_PKT] |=> cnt_q[SL_PKT] == $past(wdata));
endmodule

// File: rtl/fstat_top.sv
module fstat_top
    import fstat_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int LW = LEN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_done,
    input  logic [LW-1:0] tx_len,
    input  logic          rx_done,
    input  logic [LW-1:0] rx_len,
    input  logic          csr_wr,
    input  logic [AW-1:0] csr_addr,
    input  logic [CW-1:0] csr_wdata,
    output logic [CW-1:0] csr_rdata
);
    localparam int IW = IDX_W;

    logic          in_win;
    logic [IW-1:0] idx;
    logic          wr_ok;
    logic          tx_hit, rx_hit;
    logic [CW-1:0] tx_val, rx_val;

    assign in_win = (csr_addr[AW-1:IW+2] == (AW-IW-2)'(WIN_PAGE));
    assign idx    = csr_addr[IW+1:2];
    assign wr_ok  = csr_wr && in_win;

    fstat_bank #(.CW(CW), .LW(LW), .IW(IW), .BASE(TX_BASE), .GOCT(TX_GOCT)) u_tx (
        .clk (clk), .rst (rst), .evt (tx_done), .len (tx_len),
        .wr_en (wr_ok), .idx (idx), .wdata (csr_wdata),
        .rd_hit (tx_hit), .rd_val (tx_val)
    );

    fstat_bank #(.CW(CW), .LW(LW), .IW(IW), .BASE(RX_BASE), .GOCT(RX_GOCT)) u_rx (
        .clk (clk), .rst (rst), .evt (rx_done), .len (rx_len),
        .wr_en (wr_ok), .idx (idx), .wdata (csr_wdata),
        .rd_hit (rx_hit), .rd_val (rx_val)
    );

    always_comb begin
        csr_rdata = '0;
        if (in_win && tx_hit)      csr_rdata = tx_val;
        else if (in_win && rx_hit) csr_rdata = rx_val;
    end

    // R9: outside the window the read data is zero
    p_outside_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> csr_rdata == '0);

    // R6: the two banks never claim the same index
    p_single_bank_r6: assert property (@(posedge clk) disable iff (rst)
        !(tx_hit && rx_hit));
endmodule

// File: tb/sim_fstat_top.sv
module sim_fstat_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_done = 1'b0;
    logic [15:0] tx_len = '0;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic        csr_wr = 1'b0;
    logic [9:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int checks = 0;
    int failures = 0;
    int unsigned m [64];

    always #10 clk = ~clk;

    fstat_top u0 (
        .clk (clk), .rst (rst),
        .tx_done (tx_done), .tx_len (tx_len),
        .rx_done (rx_done), .rx_len (rx_len),
        .csr_wr (csr_wr), .csr_addr (csr_addr),
        .csr_wdata (csr_wdata), .csr_rdata (csr_rdata)
    );

    function automatic int cls_rel(input int len);
        if (len < 64)   return 7;
        if (len == 64)  return 10;
        if (len < 128)  return 11;
        if (len < 256)  return 12;
        if (len < 512)  return 13;
        if (len < 1024) return 14;
        if (len < 2048) return 15;
        return 16;
    endfunction

    function automatic bit is_impl(input int i);
        int b = (i < 32) ? 0 : 32;
        int r = i - b;
        int g = (b == 0) ? 29 : 24;
        return (r == 1 || r == 7 || (r >= 10 && r <= 17) || r == 19 || r == g);
    endfunction

    function automatic string tag_for(input int i);
        int r;
        if (!is_impl(i)) return "R9";
        if (i >= 32) return "R4";
        r = i;
        if (r == 1 || r == 19) return "R1";
        if (r == 17 || r == 29) return "R2";
        return "R3";
    endfunction

    function automatic int unsigned exp_read(input logic [9:0] a);
        if (a[9:8] != 2'b10) return 0;
        return m[int'(a[7:2])];
    endfunction

    function automatic void bump(input int base, input int goct, input int len);
        m[base + 1]  += 1;
        m[base + 19] += 1;
        m[base + 17] += len;
        m[base + goct] += len;
        m[base + cls_rel(len)] += 1;
    endfunction

    task automatic step(input bit t, input int tl, input bit r, input int rl,
                        input bit w, input logic [9:0] a, input logic [31:0] wd,
                        input string tag);
        int unsigned e;
        string tg;
        tx_done = t;  tx_len = 16'(tl);
        rx_done = r;  rx_len = 16'(rl);
        csr_wr = w;   csr_addr = a;  csr_wdata = wd;
        #1;
        e = exp_read(a);
        tg = (tag == "") ? ((a[9:8] == 2'b10) ? tag_for(int'(a[7:2])) : "R9") : tag;
        checks++;
        if (csr_rdata !== e) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tg, a, csr_rdata, e);
        end
        @(posedge clk);
        if (!rst) begin
            if (t) bump(0, 29, tl);
            if (r) bump(32, 24, rl);
            if (w && a[9:8] == 2'b10 && is_impl(int'(a[7:2]))) m[int'(a[7:2])] = wd;
        end
        @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 64; i++) step(0, 0, 0, 0, 0, 10'(32'h200 + 4 * i), 0, tag);
        step(0, 0, 0, 0, 0, 10'h000, 0, "R9");
        step(0, 0, 0, 0, 0, 10'h1FC, 0, "R9");
        step(0, 0, 0, 0, 0, 10'h300, 0, "R9");
        step(0, 0, 0, 0, 0, 10'h3FE, 0, "R9");
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int lens [15] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048, 65535};
        for (int i = 0; i < 64; i++) m[i] = 0;
        @(negedge clk);
        step(1, 100, 1, 100, 1, 10'h204, 32'hDEAD, "R10");
        rst = 1'b0;
        sweep("R10");

        // R1 R2 R3: transmit boundaries
        foreach (lens[i]) step(1, lens[i], 0, 0, 0, 10'h204, 0, "R1");
        sweep("");
        // R4: receive boundaries
        foreach (lens[i]) step(0, 0, 1, lens[i], 0, 10'h284, 0, "R4");
        sweep("");

        // R5: simultaneous updates
        for (int i = 0; i < 20; i++)
            step(1, $urandom_range(0, 3000), 1, $urandom_range(0, 3000), 0, 10'h2C4, 0, "R5");
        sweep("R5");

        // R6 R9: write every slot with random low address bits, then outside the window
        for (int i = 0; i < 64; i++)
            step(0, 0, 0, 0, 1, 10'(32'h200 + 4 * i + $urandom_range(0, 3)), 32'h1000 + i, "R6");
        sweep("R6");
        step(0, 0, 0, 0, 1, 10'h004, 32'hFFFF, "R9");
        step(0, 0, 0, 0, 1, 10'h304, 32'hFFFF, "R9");
        step(0, 0, 0, 0, 1, 10'h120, 32'hFFFF, "R9");
        sweep("R9");

        // R7: write wins over a same-cycle increment
        step(1, 64, 0, 0, 1, 10'h204, 32'h1234, "R7");
        step(0, 0, 1, 70, 1, 10'h2C4, 32'h55AA, "R7");
        step(0, 0, 0, 0, 0, 10'h204, 0, "R7");
        step(0, 0, 0, 0, 0, 10'h2C4, 0, "R7");

        // R8: wraparound
        step(0, 0, 0, 0, 1, 10'h204, 32'hFFFF_FFFF, "R8");
        step(0, 0, 0, 0, 1, 10'h244, 32'hFFFF_FFF0, "R8");
        step(1, 32, 0, 0, 0, 10'h204, 0, "R8");
        step(0, 0, 0, 0, 0, 10'h204, 0, "R8");
        step(0, 0, 0, 0, 0, 10'h244, 0, "R8");
        sweep("R8");

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            int pick = $urandom_range(0, 9);
            int tl = (pick < 2) ? lens[$urandom_range(0, 14)] : $urandom_range(0, 2200);
            int rl = (pick > 7) ? lens[$urandom_range(0, 14)] : $urandom_range(0, 2200);
            bit w = ($urandom_range(0, 15) == 0);
            step($urandom_range(0, 1), tl, $urandom_range(0, 1), rl, w,
                 10'(32'h200 + 4 * (i % 64)), $urandom, "");
        end
        sweep("");
        finish_run();
    end
endmodule